// File: doc/BRIEF.md
# Virtual-8086 Interrupt Entry Sequencer

This block carries out the privilege-change part of delivering an interrupt or exception to a ring-0 handler while the core runs in virtual-8086 mode. On an entry request it first checks the target code segment. When that check passes, it writes a stack frame of 32-bit words downward from the ring-0 stack pointer held in the task state. The frame holds the four data segment selectors, the interrupted stack, the flags, the return address and, when present, an error code. It then commits new register values: the data selectors are zeroed, the mode and trace related flags are cleared, and the instruction pointer is redirected to the handler.

A target segment that is conforming, or whose privilege level is not 0, makes the entry end before any stack write. The block then raises a general-protection fault whose code is the target selector. A second request type restores the register file from a popped frame image, as for an interrupt return. The privilege level at that moment decides whether the virtual-8086 mode bit may change.

Memory is reached through a simple valid/ready write port, one word per accepted handshake. Descriptor fetch, paging and memory reads are done by the surrounding logic.

Top module: `v86_entry_seq`

## Requirements
- R1: The frame words are written in this order: GS, FS, DS, ES, SS, interrupted ESP, EFLAGS, CS, EIP. Each selector sits zero-extended in the low 16 bits of its word.
- R2: The first write goes to `tss_esp0 - 4` and each later write goes 4 bytes below the one before. Address and data hold steady while `wr_ready` is low, and the word index moves on only on a handshake.
- R3: A tenth word carrying `ent_err_code` is written after EIP only when `ent_has_err` is 1. The committed ESP equals the address of the last word written.
- R4: At commit, DS, ES, FS and GS become 0, SS takes `tss_ss0`, CS takes `ent_cs_sel`, and EIP takes `ent_eip`.
- R5: The committed EFLAGS clears bits 17 (VM), 16 (RF), 14 (NT) and 8 (TF). It clears bit 9 (IF) only when `ent_gate_intr` is 1. All other bits keep their pre-entry values.
- R6: The EFLAGS word in the frame, and every other frame word, holds the value sampled in the request cycle, even if the inputs change later.
- R7: If `ent_cs_conf` is 1 or `ent_cs_dpl` is not 0, `gp_fault` pulses for one cycle on the cycle after the request, with `gp_code` equal to the zero-extended `ent_cs_sel`. No stack write takes place and the committed registers are left unchanged.
- R8: `ent_done` is a one-cycle pulse on the cycle after the final write handshake. With `wr_ready` held high, it rises N+1 cycles after the request for an N-word frame.
- R9: An interrupt-return request with `iret_cpl` equal to 0 loads every register output from the `img_*` inputs, VM included. `iret_done` pulses on the following cycle.
- R10: An interrupt-return request with `iret_cpl` not 0 takes EFLAGS from `img_eflags` except bit 17, which keeps the value of `cur_eflags` bit 17.
- R11: Requests that arrive while `busy` is 1 are ignored. When both request types arrive together in idle, the entry request wins and the return request is dropped.
- R12: After reset, every register output, `wr_valid`, `busy`, `gp_fault`, `ent_done` and `iret_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_req | input | 1 | Start an entry sequence (sampled in idle) |
| ent_has_err | input | 1 | Vector carries an error code |
| ent_err_code | input | 32 | Error code to push |
| ent_gate_intr | input | 1 | 1 = interrupt gate, 0 = trap gate |
| ent_cs_sel | input | 16 | Handler code-segment selector |
| ent_cs_conf | input | 1 | Handler segment is conforming |
| ent_cs_dpl | input | 2 | Handler segment privilege level |
| ent_eip | input | 32 | Handler entry offset |
| tss_esp0 | input | 32 | Ring-0 stack pointer from task state |
| tss_ss0 | input | 16 | Ring-0 stack selector from task state |
| cur_cs | input | 16 | Interrupted CS |
| cur_ss | input | 16 | Interrupted SS |
| cur_ds | input | 16 | Interrupted DS |
| cur_es | input | 16 | Interrupted ES |
| cur_fs | input | 16 | Interrupted FS |
| cur_gs | input | 16 | Interrupted GS |
| cur_esp | input | 32 | Interrupted ESP |
| cur_eip | input | 32 | Interrupted EIP |
| cur_eflags | input | 32 | Current EFLAGS |
| iret_req | input | 1 | Restore registers from a popped frame |
| iret_cpl | input | 2 | Privilege level at the return |
| img_cs | input | 16 | Popped CS |
| img_ss | input | 16 | Popped SS |
| img_ds | input | 16 | Popped DS |
| img_es | input | 16 | Popped ES |
| img_fs | input | 16 | Popped FS |
| img_gs | input | 16 | Popped GS |
| img_esp | input | 32 | Popped ESP |
| img_eip | input | 32 | Popped EIP |
| img_eflags | input | 32 | Popped EFLAGS |
| wr_valid | output | 1 | Stack write pending |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Stack write byte address |
| wr_data | output | 32 | Stack write word |
| busy | output | 1 | Entry frame in progress |
| gp_fault | output | 1 | General-protection fault pulse |
| gp_code | output | 32 | Fault error code |
| ent_done | output | 1 | Entry commit pulse |
| iret_done | output | 1 | Return commit pulse |
| o_cs | output | 16 | Committed CS |
| o_ss | output | 16 | Committed SS |
| o_ds | output | 16 | Committed DS |
| o_es | output | 16 | Committed ES |
| o_fs | output | 16 | Committed FS |
| o_gs | output | 16 | Committed GS |
| o_esp | output | 32 | Committed ESP |
| o_eip | output | 32 | Committed EIP |
| o_eflags | output | 32 | Committed EFLAGS |

## Verification
The assertions check the following on every cycle:
- the write port holds address and data through stalls;
- consecutive writes step down by one word;
- a fault never coincides with a write or a busy sequencer;
- every entry commit leaves zeroed data selectors and cleared VM, NT, RF and TF;
- the return path preserves VM when the privilege level is not 0.

The bench scenarios cover what needs the request history:
- the exact frame order and contents;
- the presence of the error-code word and the final stack pointer;
- the IF rule, which depends on the gate type;
- that sampled values survive input changes;
- the drop of requests made while busy;
- the entry-over-return priority.

// File: rtl/v86_pkg.sv
// Package v86_pkg
// Shared constants and types for the virtual-8086 entry sequencer.
// Assumes a 32-bit flag word with the conventional bit positions.
package v86_pkg;

    // Flag bit positions the sequencer manipulates
    localparam int FL_TF = 8;
    localparam int FL_IF = 9;
    localparam int FL_NT = 14;
    localparam int FL_RF = 16;
    localparam int FL_VM = 17;

    // Frame slot count when an error code is present
    localparam int FRAME_SLOTS_MAX = 10;

    // Slot order in the frame, lowest index written first (highest address)
    localparam int SLOT_GS     = 0;
    localparam int SLOT_FS     = 1;
    localparam int SLOT_DS     = 2;
    localparam int SLOT_ES     = 3;
    localparam int SLOT_SS     = 4;
    localparam int SLOT_ESP    = 5;
    localparam int SLOT_EFLAGS = 6;
    localparam int SLOT_CS     = 7;
    localparam int SLOT_EIP    = 8;
    localparam int SLOT_ERR    = 9;

    // Number of selector-carrying slots at the start of the frame
    localparam int SEL_SLOTS = 5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PUSH = 1'b1
    } seq_st_t;

endpackage

// File: rtl/v86_gate_check.sv
// Module v86_gate_check
// Decides whether the handler code segment may be entered from
// virtual-8086 mode: it must be non-conforming and at privilege 0.
// Produces the fault error code (zero-extended selector).
// Purely combinational; inputs are valid in the request cycle.
module v86_gate_check #(
    parameter int SEL_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic              cs_conf,
    input  logic [1:0]        cs_dpl,
    input  logic [SEL_W-1:0]  cs_sel,
    output logic              fault,
    output logic [WORD_W-1:0] fault_code
);

    // Target segment legality test
    always_comb begin
        fault = cs_conf || (cs_dpl != 2'd0);
    end

    // Fault code is the attempted selector, widened
    always_comb begin
        fault_code = '0;
        fault_code[SEL_W-1:0] = cs_sel;
    end

endmodule

// File: rtl/v86_frame_mux.sv
// Module v86_frame_mux
// Selects the word for the current frame slot from the captured
// interrupted state. Selector slots are zero-extended; unused index
// values read as zero. Purely combinational.
module v86_frame_mux #(
    parameter int SEL_W  = 16,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [SEL_W-1:0]  gs,
    input  logic [SEL_W-1:0]  fs,
    input  logic [SEL_W-1:0]  ds,
    input  logic [SEL_W-1:0]  es,
    input  logic [SEL_W-1:0]  ss,
    input  logic [SEL_W-1:0]  cs,
    input  logic [WORD_W-1:0] esp,
    input  logic [WORD_W-1:0] eflags,
    input  logic [WORD_W-1:0] eip,
    input  logic [WORD_W-1:0] err,
    output logic [WORD_W-1:0] word
);
    import v86_pkg::*;

    localparam int TBL = 2 ** IDX_W;

    logic [SEL_W-1:0]  sel_arr [SEL_SLOTS];
    logic [WORD_W-1:0] slot_w  [TBL];

    assign sel_arr[SLOT_GS] = gs;
    assign sel_arr[SLOT_FS] = fs;
    assign sel_arr[SLOT_DS] = ds;
    assign sel_arr[SLOT_ES] = es;
    assign sel_arr[SLOT_SS] = ss;

    genvar g;
    generate
        // Selector slots: zero-extend into the low bits
        for (g = 0; g < SEL_SLOTS; g++) begin : g_sel
            assign slot_w[g] = {{(WORD_W-SEL_W){1'b0}}, sel_arr[g]};
        end
        // Unused table entries beyond the frame read as zero
        for (g = FRAME_SLOTS_MAX; g < TBL; g++) begin : g_pad
            assign slot_w[g] = '0;
        end
    endgenerate

    assign slot_w[SLOT_ESP]    = esp;
    assign slot_w[SLOT_EFLAGS] = eflags;
    assign slot_w[SLOT_CS]     = {{(WORD_W-SEL_W){1'b0}}, cs};
    assign slot_w[SLOT_EIP]    = eip;
    assign slot_w[SLOT_ERR]    = err;

    // Slot word selection
    always_comb begin
        word = slot_w[idx];
    end

endmodule

// File: rtl/v86_flag_xform.sv
// Module v86_flag_xform
// Computes the flag word committed on entry (mode, nesting, resume and
// trace cleared; interrupt-enable cleared for interrupt gates) and the
// flag word restored on return (mode bit may only change at CPL 0).
// Purely combinational.
module v86_flag_xform #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] ent_in,
    input  logic              ent_intr,
    output logic [WORD_W-1:0] ent_out,
    input  logic [WORD_W-1:0] ret_img,
    input  logic              ret_cur_vm,
    input  logic [1:0]        ret_cpl,
    output logic [WORD_W-1:0] ret_out
);
    import v86_pkg::*;

    logic [WORD_W-1:0] clr_mask;

    // Build the set of bits cleared on entry
    always_comb begin
        clr_mask = '0;
        clr_mask[FL_VM] = 1'b1;
        clr_mask[FL_NT] = 1'b1;
        clr_mask[FL_RF] = 1'b1;
        clr_mask[FL_TF] = 1'b1;
        clr_mask[FL_IF] = ent_intr;
    end

    // Entry flag word
    always_comb begin
        ent_out = ent_in & ~clr_mask;
    end

    // Return flag word: mode bit guarded by privilege level
    always_comb begin
        ret_out = ret_img;
        if (ret_cpl != 2'd0) begin
            ret_out[FL_VM] = ret_cur_vm;
        end
    end

endmodule

// File: rtl/v86_entry_seq.sv
// Module v86_entry_seq (top)
// Sequences virtual-8086 interrupt entry: checks the handler segment,
// writes the ring-0 frame one word per handshake downward from the task
// stack pointer, then commits zeroed data selectors, cleared flags and
// the handler address. Also commits register images on return.
// Assumes: requests are single-cycle strobes, honoured only when idle;
// the write port accepts a word when wr_valid and wr_ready are both high.
module v86_entry_seq #(
    parameter int SEL_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_req,
    input  logic              ent_has_err,
    input  logic [WORD_W-1:0] ent_err_code,
    input  logic              ent_gate_intr,
    input  logic [SEL_W-1:0]  ent_cs_sel,
    input  logic              ent_cs_conf,
    input  logic [1:0]        ent_cs_dpl,
    input  logic [WORD_W-1:0] ent_eip,
    input  logic [WORD_W-1:0] tss_esp0,
    input  logic [SEL_W-1:0]  tss_ss0,
    input  logic [SEL_W-1:0]  cur_cs,
    input  logic [SEL_W-1:0]  cur_ss,
    input  logic [SEL_W-1:0]  cur_ds,
    input  logic [SEL_W-1:0]  cur_es,
    input  logic [SEL_W-1:0]  cur_fs,
    input  logic [SEL_W-1:0]  cur_gs,
    input  logic [WORD_W-1:0] cur_esp,
    input  logic [WORD_W-1:0] cur_eip,
    input  logic [WORD_W-1:0] cur_eflags,
    input  logic              iret_req,
    input  logic [1:0]        iret_cpl,
    input  logic [SEL_W-1:0]  img_cs,
    input  logic [SEL_W-1:0]  img_ss,
    input  logic [SEL_W-1:0]  img_ds,
    input  logic [SEL_W-1:0]  img_es,
    input  logic [SEL_W-1:0]  img_fs,
    input  logic [SEL_W-1:0]  img_gs,
    input  logic [WORD_W-1:0] img_esp,
    input  logic [WORD_W-1:0] img_eip,
    input  logic [WORD_W-1:0] img_eflags,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              busy,
    output logic              gp_fault,
    output logic [WORD_W-1:0] gp_code,
    output logic              ent_done,
    output logic              iret_done,
    output logic [SEL_W-1:0]  o_cs,
    output logic [SEL_W-1:0]  o_ss,
    output logic [SEL_W-1:0]  o_ds,
    output logic [SEL_W-1:0]  o_es,
    output logic [SEL_W-1:0]  o_fs,
    output logic [SEL_W-1:0]  o_gs,
    output logic [WORD_W-1:0] o_esp,
    output logic [WORD_W-1:0] o_eip,
    output logic [WORD_W-1:0] o_eflags
);
    import v86_pkg::*;

    localparam int IDX_W      = $clog2(FRAME_SLOTS_MAX);
    localparam int SLOT_BYTES = WORD_W / 8;
    localparam logic [IDX_W-1:0] LAST_ERR   = IDX_W'(FRAME_SLOTS_MAX - 1);
    localparam logic [IDX_W-1:0] LAST_NOERR = IDX_W'(FRAME_SLOTS_MAX - 2);

    seq_st_t           st;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] ptr;

    // Captured request state
    logic [SEL_W-1:0]  s_gs, s_fs, s_ds, s_es, s_ss, s_cs;
    logic [WORD_W-1:0] s_esp, s_eip, s_eflags, s_err;
    logic              s_has_err, s_intr;
    logic [SEL_W-1:0]  s_tgt_sel, s_ss0;
    logic [WORD_W-1:0] s_tgt_eip;

    logic              chk_fault;
    logic [WORD_W-1:0] chk_code;
    logic [WORD_W-1:0] frame_word;
    logic [WORD_W-1:0] ent_flags;
    logic [WORD_W-1:0] ret_flags;
    logic [IDX_W-1:0]  last_idx;
    logic              wr_fire;

    v86_gate_check #(
        .SEL_W  (SEL_W),
        .WORD_W (WORD_W)
    ) u_gate (
        .cs_conf    (ent_cs_conf),
        .cs_dpl     (ent_cs_dpl),
        .cs_sel     (ent_cs_sel),
        .fault      (chk_fault),
        .fault_code (chk_code)
    );

    v86_frame_mux #(
        .SEL_W  (SEL_W),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_mux (
        .idx    (idx),
        .gs     (s_gs),
        .fs     (s_fs),
        .ds     (s_ds),
        .es     (s_es),
        .ss     (s_ss),
        .cs     (s_cs),
        .esp    (s_esp),
        .eflags (s_eflags),
        .eip    (s_eip),
        .err    (s_err),
        .word   (frame_word)
    );

    v86_flag_xform #(
        .WORD_W (WORD_W)
    ) u_flags (
        .ent_in     (s_eflags),
        .ent_intr   (s_intr),
        .ent_out    (ent_flags),
        .ret_img    (img_eflags),
        .ret_cur_vm (cur_eflags[FL_VM]),
        .ret_cpl    (iret_cpl),
        .ret_out    (ret_flags)
    );

    // Write port and status decode
    always_comb begin
        wr_valid = (st == ST_PUSH);
        wr_addr  = ptr;
        wr_data  = frame_word;
        busy     = (st == ST_PUSH);
        wr_fire  = wr_valid && wr_ready;
        last_idx = s_has_err ? LAST_ERR : LAST_NOERR;
    end

    // Sequencer state, slot index and stack pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            idx <= '0;
            ptr <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (ent_req && !chk_fault) begin
                        st  <= ST_PUSH;
                        idx <= '0;
                        ptr <= tss_esp0 - WORD_W'(SLOT_BYTES);
                    end
                end
                ST_PUSH: begin
                    if (wr_fire) begin
                        if (idx == last_idx) begin
                            st <= ST_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                            ptr <= ptr - WORD_W'(SLOT_BYTES);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Capture interrupted state and entry parameters on an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_gs      <= '0;
            s_fs      <= '0;
            s_ds      <= '0;
            s_es      <= '0;
            s_ss      <= '0;
            s_cs      <= '0;
            s_esp     <= '0;
            s_eip     <= '0;
            s_eflags  <= '0;
            s_err     <= '0;
            s_has_err <= 1'b0;
            s_intr    <= 1'b0;
            s_tgt_sel <= '0;
            s_ss0     <= '0;
            s_tgt_eip <= '0;
        end else if (st == ST_IDLE && ent_req && !chk_fault) begin
            s_gs      <= cur_gs;
            s_fs      <= cur_fs;
            s_ds      <= cur_ds;
            s_es      <= cur_es;
            s_ss      <= cur_ss;
            s_cs      <= cur_cs;
            s_esp     <= cur_esp;
            s_eip     <= cur_eip;
            s_eflags  <= cur_eflags;
            s_err     <= ent_err_code;
            s_has_err <= ent_has_err;
            s_intr    <= ent_gate_intr;
            s_tgt_sel <= ent_cs_sel;
            s_ss0     <= tss_ss0;
            s_tgt_eip <= ent_eip;
        end
    end

    // Fault reporting: pulse plus held error code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gp_fault <= 1'b0;
            gp_code  <= '0;
        end else begin
            gp_fault <= 1'b0;
            if (st == ST_IDLE && ent_req && chk_fault) begin
                gp_fault <= 1'b1;
                gp_code  <= chk_code;
            end
        end
    end

    // Architectural register commit for entry and return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_done  <= 1'b0;
            iret_done <= 1'b0;
            o_cs      <= '0;
            o_ss      <= '0;
            o_ds      <= '0;
            o_es      <= '0;
            o_fs      <= '0;
            o_gs      <= '0;
            o_esp     <= '0;
            o_eip     <= '0;
            o_eflags  <= '0;
        end else begin
            ent_done  <= 1'b0;
            iret_done <= 1'b0;
            if (st == ST_PUSH && wr_fire && idx == last_idx) begin
                ent_done <= 1'b1;
                o_cs     <= s_tgt_sel;
                o_ss     <= s_ss0;
                o_ds     <= '0;
                o_es     <= '0;
                o_fs     <= '0;
                o_gs     <= '0;
                o_esp    <= ptr;
                o_eip    <= s_tgt_eip;
                o_eflags <= ent_flags;
            end else if (st == ST_IDLE && !ent_req && iret_req) begin
                iret_done <= 1'b1;
                o_cs      <= img_cs;
                o_ss      <= img_ss;
                o_ds      <= img_ds;
                o_es      <= img_es;
                o_fs      <= img_fs;
                o_gs      <= img_gs;
                o_esp     <= img_esp;
                o_eip     <= img_eip;
                o_eflags  <= ret_flags;
            end
        end
    end

endmodule

// File: rtl/v86_entry_seq_chk.sv
// Module v86_entry_seq_chk
// Property checker bound to v86_entry_seq. Observes ports only.
module v86_entry_seq_chk #(
    parameter int SEL_W  = 16,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [WORD_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              busy,
    input logic              gp_fault,
    input logic              ent_done,
    input logic              iret_done,
    input logic [1:0]        iret_cpl,
    input logic [WORD_W-1:0] cur_eflags,
    input logic [SEL_W-1:0]  o_ds,
    input logic [SEL_W-1:0]  o_es,
    input logic [SEL_W-1:0]  o_fs,
    input logic [SEL_W-1:0]  o_gs,
    input logic [WORD_W-1:0] o_eflags
);
    import v86_pkg::*;

    // R2: a stalled write keeps its address and data
    p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R2: the next write after a handshake is one word lower
    p_wr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) - WORD_W'(WORD_W/8))));

    // R7: a fault never accompanies a stack write or a running sequence
    p_fault_nowr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> (!wr_valid && !busy));

    // R4: data selectors are zero at every entry commit
    p_segs_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ent_done |-> (o_ds == '0 && o_es == '0 && o_fs == '0 && o_gs == '0));

    // R5: mode, nesting, resume and trace flags are clear at every entry commit
    p_flags_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ent_done |-> (!o_eflags[FL_VM] && !o_eflags[FL_NT] && !o_eflags[FL_RF] && !o_eflags[FL_TF]));

    // R8: the entry commit is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ent_done |=> !ent_done);

    // R10: a return at nonzero privilege keeps the current mode bit
    p_iret_vm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (iret_done && $past(iret_cpl) != 2'd0) |-> (o_eflags[FL_VM] == $past(cur_eflags[FL_VM])));

    // R11: the two commit pulses never coincide
    p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ent_done && iret_done));

endmodule

bind v86_entry_seq v86_entry_seq_chk #(
    .SEL_W  (SEL_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .busy       (busy),
    .gp_fault   (gp_fault),
    .ent_done   (ent_done),
    .iret_done  (iret_done),
    .iret_cpl   (iret_cpl),
    .cur_eflags (cur_eflags),
    .o_ds       (o_ds),
    .o_es       (o_es),
    .o_fs       (o_fs),
    .o_gs       (o_gs),
    .o_eflags   (o_eflags)
);

// File: tb/tb_v86_entry_seq.sv
// Directed bench for v86_entry_seq: one task per scenario.
module tb_v86_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ent_req = 1'b0, ent_has_err = 1'b0, ent_gate_intr = 1'b0;
    logic [31:0] ent_err_code = '0, ent_eip = '0, tss_esp0 = '0;
    logic [15:0] ent_cs_sel = '0, tss_ss0 = '0;
    logic        ent_cs_conf = 1'b0;
    logic [1:0]  ent_cs_dpl = '0;
    logic [15:0] cur_cs = '0, cur_ss = '0, cur_ds = '0, cur_es = '0, cur_fs = '0, cur_gs = '0;
    logic [31:0] cur_esp = '0, cur_eip = '0, cur_eflags = '0;
    logic        iret_req = 1'b0;
    logic [1:0]  iret_cpl = '0;
    logic [15:0] img_cs = '0, img_ss = '0, img_ds = '0, img_es = '0, img_fs = '0, img_gs = '0;
    logic [31:0] img_esp = '0, img_eip = '0, img_eflags = '0;
    logic        wr_valid, wr_ready = 1'b1;
    logic [31:0] wr_addr, wr_data;
    logic        busy, gp_fault, ent_done, iret_done;
    logic [31:0] gp_code;
    logic [15:0] o_cs, o_ss, o_ds, o_es, o_fs, o_gs;
    logic [31:0] o_esp, o_eip, o_eflags;

    v86_entry_seq dut (
        .clk(clk), .rst_n(rst_n),
        .ent_req(ent_req), .ent_has_err(ent_has_err), .ent_err_code(ent_err_code),
        .ent_gate_intr(ent_gate_intr), .ent_cs_sel(ent_cs_sel), .ent_cs_conf(ent_cs_conf),
        .ent_cs_dpl(ent_cs_dpl), .ent_eip(ent_eip), .tss_esp0(tss_esp0), .tss_ss0(tss_ss0),
        .cur_cs(cur_cs), .cur_ss(cur_ss), .cur_ds(cur_ds), .cur_es(cur_es),
        .cur_fs(cur_fs), .cur_gs(cur_gs), .cur_esp(cur_esp), .cur_eip(cur_eip),
        .cur_eflags(cur_eflags), .iret_req(iret_req), .iret_cpl(iret_cpl),
        .img_cs(img_cs), .img_ss(img_ss), .img_ds(img_ds), .img_es(img_es),
        .img_fs(img_fs), .img_gs(img_gs), .img_esp(img_esp), .img_eip(img_eip),
        .img_eflags(img_eflags), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .gp_fault(gp_fault),
        .gp_code(gp_code), .ent_done(ent_done), .iret_done(iret_done),
        .o_cs(o_cs), .o_ss(o_ss), .o_ds(o_ds), .o_es(o_es), .o_fs(o_fs), .o_gs(o_gs),
        .o_esp(o_esp), .o_eip(o_eip), .o_eflags(o_eflags)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rec_addr [16];
    logic [31:0] rec_data [16];
    int  n_rec = 0;
    bit  stall_en = 1'b0;
    bit  tick = 1'b0;

    // Ready pattern: always ready, or every other cycle when stalling
    always @(negedge clk) begin
        tick     <= ~tick;
        wr_ready <= stall_en ? tick : 1'b1;
    end

    // Record each write that will be accepted at the next rising edge
    always begin
        @(negedge clk);
        #1;
        if (wr_valid && wr_ready && n_rec < 16) begin
            rec_addr[n_rec] = wr_addr;
            rec_data[n_rec] = wr_data;
            n_rec = n_rec + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ent_mask(input bit intr);
        logic [31:0] m;
        m = 32'h0;
        m[17] = 1'b1; m[16] = 1'b1; m[14] = 1'b1; m[8] = 1'b1; m[9] = intr;
        return ~m;
    endfunction

    // Drive one entry request and wait for commit; optionally poke requests while busy
    task automatic run_entry(input bit has_err, input bit intr, input bit stall, input bit poke,
                             input logic [31:0] fl, input string tag);
        logic [31:0] exp_w [10];
        int n, cyc;
        logic [31:0] esp0;
        bit seen_iret;
        esp0 = 32'h0000_2000;
        @(negedge clk);
        stall_en      = stall;
        n_rec         = 0;
        cur_gs = 16'h1111; cur_fs = 16'h2222; cur_ds = 16'h3333; cur_es = 16'h4444;
        cur_ss = 16'h5555; cur_cs = 16'h6666; cur_esp = 32'h0000_FFF0;
        cur_eip = 32'h0000_0123; cur_eflags = fl;
        ent_has_err = has_err; ent_err_code = 32'h0000_00E5; ent_gate_intr = intr;
        ent_cs_sel = 16'h0008; ent_cs_conf = 1'b0; ent_cs_dpl = 2'd0;
        ent_eip = 32'hC000_1000; tss_esp0 = esp0; tss_ss0 = 16'h0010;
        ent_req = 1'b1;
        iret_req = poke;  // simultaneous return request must lose (R11)
        exp_w[0] = 32'h1111; exp_w[1] = 32'h2222; exp_w[2] = 32'h3333; exp_w[3] = 32'h4444;
        exp_w[4] = 32'h5555; exp_w[5] = 32'h0000_FFF0; exp_w[6] = fl; exp_w[7] = 32'h6666;
        exp_w[8] = 32'h0000_0123; exp_w[9] = 32'h0000_00E5;
        n = has_err ? 10 : 9;
        cyc = 0;
        seen_iret = 1'b0;
        @(negedge clk);
        ent_req = 1'b0; iret_req = 1'b0;
        // change the live inputs: frame must still use sampled values (R6)
        cur_eflags = ~fl; cur_gs = 16'hDEAD; ent_err_code = 32'hBAD0;
        cyc = 1;
        while (!ent_done && cyc < 200) begin
            if (poke && cyc == 3) begin
                ent_req = 1'b1; iret_req = 1'b1; ent_cs_sel = 16'h0099;
            end else begin
                ent_req = 1'b0; iret_req = 1'b0;
            end
            if (iret_done) seen_iret = 1'b1;
            @(negedge clk);
            cyc++;
        end
        ent_req = 1'b0; iret_req = 1'b0;
        chk({"R8 done seen ", tag}, {31'b0, ent_done}, 32'd1);
        if (!stall) chk({"R8 done latency ", tag}, cyc, n + 1);
        chk({"R3 write count ", tag}, n_rec, n);
        for (int i = 0; i < n && i < n_rec; i++) begin
            chk({"R2 addr ", tag}, rec_addr[i], esp0 - 32'(4 * (i + 1)));
            chk({(i == 6) ? "R6 eflags word " : (i == 9) ? "R3 err word " : "R1 word ", tag},
                rec_data[i], exp_w[i]);
        end
        chk({"R3 final esp ", tag}, o_esp, esp0 - 32'(4 * n));
        chk({"R4 cs ", tag}, {16'h0, o_cs}, 32'h0008);
        chk({"R4 ss ", tag}, {16'h0, o_ss}, 32'h0010);
        chk({"R4 eip ", tag}, o_eip, 32'hC000_1000);
        chk({"R4 data segs ", tag}, {o_ds | o_es, o_fs | o_gs}, 32'h0);
        chk({"R5 eflags ", tag}, o_eflags, fl & ent_mask(intr));
        if (poke) chk({"R11 no return commit ", tag}, {31'b0, seen_iret | iret_done}, 32'd0);
        @(negedge clk);
        chk({"R8 done pulse ", tag}, {31'b0, ent_done}, 32'd0);
        if (poke) chk({"R11 no second frame ", tag}, {31'b0, busy}, 32'd0);
        stall_en = 1'b0;
        repeat (2) @(negedge clk);
        if (poke) chk({"R11 no writes after ", tag}, n_rec, n);
    endtask

    task automatic t_reset;
        chk("R12 wr_valid", {31'b0, wr_valid}, 32'd0);
        chk("R12 busy", {31'b0, busy}, 32'd0);
        chk("R12 pulses", {29'b0, gp_fault, ent_done, iret_done}, 32'd0);
        chk("R12 eflags", o_eflags, 32'd0);
        chk("R12 esp", o_esp, 32'd0);
        chk("R12 cs", {16'h0, o_cs}, 32'd0);
    endtask

    task automatic t_fault(input bit conf, input logic [1:0] dpl, input logic [15:0] sel, input string tag);
        logic [31:0] prev_esp, prev_fl;
        logic [15:0] prev_cs;
        @(negedge clk);
        prev_esp = o_esp; prev_fl = o_eflags; prev_cs = o_cs;
        n_rec = 0;
        ent_cs_conf = conf; ent_cs_dpl = dpl; ent_cs_sel = sel; tss_esp0 = 32'h3000;
        ent_req = 1'b1;
        @(negedge clk);
        ent_req = 1'b0;
        chk({"R7 fault pulse ", tag}, {31'b0, gp_fault}, 32'd1);
        chk({"R7 fault code ", tag}, gp_code, {16'h0, sel});
        chk({"R7 not busy ", tag}, {31'b0, busy}, 32'd0);
        @(negedge clk);
        chk({"R7 pulse ends ", tag}, {31'b0, gp_fault}, 32'd0);
        repeat (3) @(negedge clk);
        chk({"R7 no writes ", tag}, n_rec, 32'd0);
        chk({"R7 esp kept ", tag}, o_esp, prev_esp);
        chk({"R7 eflags kept ", tag}, o_eflags, prev_fl);
        chk({"R7 cs kept ", tag}, {16'h0, o_cs}, {16'h0, prev_cs});
        chk({"R7 no commit ", tag}, {31'b0, ent_done}, 32'd0);
        ent_cs_conf = 1'b0; ent_cs_dpl = 2'd0;
    endtask

    task automatic t_iret(input logic [1:0] cpl, input logic [31:0] img_fl, input logic [31:0] live_fl,
                          input string tag);
        logic [31:0] exp_fl;
        @(negedge clk);
        img_cs = 16'h0F0F; img_ss = 16'h1E1E; img_ds = 16'h2D2D; img_es = 16'h3C3C;
        img_fs = 16'h4B4B; img_gs = 16'h5A5A; img_esp = 32'h0000_7FFC; img_eip = 32'h0000_0456;
        img_eflags = img_fl; cur_eflags = live_fl; iret_cpl = cpl;
        iret_req = 1'b1;
        @(negedge clk);
        iret_req = 1'b0;
        exp_fl = img_fl;
        if (cpl != 2'd0) exp_fl[17] = live_fl[17];
        chk({"R9 done pulse ", tag}, {31'b0, iret_done}, 32'd1);
        chk({cpl == 2'd0 ? "R9 eflags " : "R10 eflags ", tag}, o_eflags, exp_fl);
        chk({"R9 segs ", tag}, {o_ds, o_gs}, 32'h2D2D_5A5A);
        chk({"R9 cs ss ", tag}, {o_cs, o_ss}, 32'h0F0F_1E1E);
        chk({"R9 esp ", tag}, o_esp, 32'h0000_7FFC);
        chk({"R9 eip ", tag}, o_eip, 32'h0000_0456);
        @(negedge clk);
        chk({"R9 pulse ends ", tag}, {31'b0, iret_done}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        run_entry(1'b0, 1'b1, 1'b0, 1'b0, 32'h0003_4346, "intr noerr");
        run_entry(1'b1, 1'b0, 1'b1, 1'b0, 32'h0002_C3D7, "trap err stall");
        run_entry(1'b1, 1'b1, 1'b0, 1'b1, 32'h0002_0202, "busy poke");
        t_fault(1'b1, 2'd0, 16'h0018, "conforming");
        t_fault(1'b0, 2'd3, 16'h002B, "dpl3");
        t_iret(2'd0, 32'h0002_0202, 32'h0000_0002, "cpl0 vm set");
        t_iret(2'd3, 32'h0002_0246, 32'h0000_0002, "cpl3 vm kept0");
        t_iret(2'd3, 32'h0000_0A13, 32'h0002_0002, "cpl3 vm kept1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule